// File: doc/BRIEF.md
# Supply Enable Step with Timeout Trap

This block is one step of a power-up sequence. A start request from idle latches a timeout, raises the enable for one supply and then waits for that rail's good flag. The good flag means the rail has crossed its undervoltage threshold. When the rail comes good, the step advances to its done state and raises a second enable for the next step. If the rail is still not good when the timeout runs out, the step turns off the supply enable and raises a fault indicator. It then stays there until it is explicitly restarted.

The timeout is counted in ticks of an external microsecond strobe. It can be set anywhere from 100 µs to 400 ms, and 10 ms is a common choice. A value outside that window is clamped to the nearest bound. The setting is captured once, when the wait begins. A later change on the setting input cannot stretch or shorten a wait that is already under way. The analog comparison that produces the rail-good flag lives outside this block.

Top module: `seqstep_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, state_o reads 0 (idle) and supply_en, next_en and fault_o are low. A reset during a wait also returns the step to idle.
- R2: A start pulse in idle moves state_o to 1 (waiting) on the next edge, and supply_en is high from that same cycle. A start pulse in any other state has no effect.
- R3: While waiting, the timeout count starts at 0 and advances by one for each clock edge on which tick is high. It stops at the latched limit. Without rail_good the step stays waiting while the count is below the limit.
- R4: rail_good high at a clock edge while waiting moves state_o to 2 (done). In done, supply_en and next_en are high and fault_o is low.
- R5: If rail_good is low at an edge while waiting and the count equals the limit, state_o moves to 3 (fault). In fault, supply_en and next_en are low and fault_o is high.
- R6: If rail_good is high at the same edge where the count has reached the limit, the step goes to done, not fault.
- R7: Done and fault hold until restart is high at an edge, which returns the step to idle with all outputs low. restart has no effect in idle or while waiting.
- R8: A timeout setting below MIN_TO is taken as MIN_TO. A setting above MAX_TO is taken as MAX_TO.
- R9: The limit is captured from timeout_us at the start edge. Changes on timeout_us after that edge do not affect the current wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the step from idle |
| restart | input | 1 | Return from done or fault to idle |
| tick | input | 1 | One-cycle strobe each microsecond |
| rail_good | input | 1 | Monitored rail is above its undervoltage threshold |
| timeout_us | input | TO_W | Timeout in ticks, clamped to [MIN_TO, MAX_TO] |
| supply_en | output | 1 | Enable for the supply under test |
| next_en | output | 1 | Enable for the following sequence step |
| fault_o | output | 1 | Timeout fault indicator |
| state_o | output | 2 | 0 idle, 1 waiting, 2 done, 3 fault |

## Verification
The hardest case to reach from the ports is the exact boundary: rail_good rising on the very edge where the tick count has just reached the limit, with ticks arriving at an irregular rate. The bench keeps its own tick count, updated every cycle. It raises rail_good at the cycle its count reaches a chosen arrival value and sweeps that arrival from zero to past the limit. It does this for several limits, including clamped ones, and for two tick rates. On alternate runs it also changes the timeout input during the wait.

// File: rtl/seqstep_pkg.sv
package seqstep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DONE  = 2'd2,
    ST_FAULT = 2'd3
  } step_state_t;
endpackage

// File: rtl/seqstep_limit.sv
// Captures the clamped timeout setting when a wait is launched.
module seqstep_limit #(
  parameter int TO_W   = 20,
  parameter int MIN_TO = 100,
  parameter int MAX_TO = 400000,
  localparam int CNT_W = $clog2(MAX_TO + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TO_W-1:0]  setting,
  output logic [CNT_W-1:0] lim
);
  logic [CNT_W-1:0] clamped;

  always_comb begin
    if (setting < TO_W'(MIN_TO))
      clamped = CNT_W'(MIN_TO);
    else if (setting > TO_W'(MAX_TO))
      clamped = CNT_W'(MAX_TO);
    else
      clamped = setting[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)       lim <= CNT_W'(MIN_TO);
    else if (load) lim <= clamped;
  end
endmodule

// File: rtl/seqstep_timer.sv
// Counts ticks while the step waits; cleared whenever it is not waiting.
module seqstep_timer #(
  parameter int MAX_TO = 400000,
  localparam int CNT_W = $clog2(MAX_TO + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic [CNT_W-1:0] lim,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);
  assign expired = run && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (tick && (cnt < lim))
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/seqstep_fsm.sv
// Step state machine with outputs registered from the next-state decode.
module seqstep_fsm
  import seqstep_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        restart,
  input  logic        rail_good,
  input  logic        expired,
  output step_state_t state,
  output logic        load,
  output logic        supply_en,
  output logic        next_en,
  output logic        fault_o
);
  step_state_t nxt;

  assign load = (state == ST_IDLE) && start;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start) nxt = ST_WAIT;
      ST_WAIT: begin
        if (rail_good)    nxt = ST_DONE;   // good rail outranks expiry
        else if (expired) nxt = ST_FAULT;
      end
      ST_DONE:  if (restart) nxt = ST_IDLE;
      ST_FAULT: if (restart) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      supply_en <= 1'b0;
      next_en   <= 1'b0;
      fault_o   <= 1'b0;
    end else begin
      state     <= nxt;
      supply_en <= (nxt == ST_WAIT) || (nxt == ST_DONE);
      next_en   <= (nxt == ST_DONE);
      fault_o   <= (nxt == ST_FAULT);
    end
  end
endmodule

// File: rtl/seqstep_top.sv
module seqstep_top
  import seqstep_pkg::*;
#(
  parameter int TO_W   = 20,
  parameter int MIN_TO = 100,
  parameter int MAX_TO = 400000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            restart,
  input  logic            tick,
  input  logic            rail_good,
  input  logic [TO_W-1:0] timeout_us,
  output logic            supply_en,
  output logic            next_en,
  output logic            fault_o,
  output logic [1:0]      state_o
);
  localparam int CNT_W = $clog2(MAX_TO + 1);

  step_state_t      state;
  logic             load;
  logic             expired;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] tmr_cnt;

  seqstep_limit #(.TO_W(TO_W), .MIN_TO(MIN_TO), .MAX_TO(MAX_TO)) u_limit (
    .clk(clk), .rst(rst), .load(load), .setting(timeout_us), .lim(lim)
  );

  seqstep_timer #(.MAX_TO(MAX_TO)) u_timer (
    .clk(clk), .rst(rst), .run(state == ST_WAIT), .tick(tick),
    .lim(lim), .cnt(tmr_cnt), .expired(expired)
  );

  seqstep_fsm u_fsm (
    .clk(clk), .rst(rst), .start(start), .restart(restart),
    .rail_good(rail_good), .expired(expired), .state(state), .load(load),
    .supply_en(supply_en), .next_en(next_en), .fault_o(fault_o)
  );

  assign state_o = state;
endmodule

// File: rtl/seqstep_chk.sv
module seqstep_chk #(
  parameter int MIN_TO = 100,
  parameter int MAX_TO = 400000,
  localparam int CNT_W = $clog2(MAX_TO + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             restart,
  input logic             rail_good,
  input logic [1:0]       state_o,
  input logic             supply_en,
  input logic             next_en,
  input logic             fault_o,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] lim
);
  AST_WAIT_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1) |-> (supply_en && !next_en && !fault_o)); // R2
  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    cnt <= lim); // R3
  AST_NO_EARLY_FAULT: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1 && !rail_good && cnt < lim) |=> (state_o == 2'd1)); // R3
  AST_GOOD_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1 && rail_good) |=> (state_o == 2'd2)); // R6
  AST_DONE_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2) |-> (supply_en && next_en && !fault_o)); // R4
  AST_FAULT_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd3) |-> (fault_o && !supply_en && !next_en)); // R5
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd3 && !restart) |=> (state_o == 2'd3)); // R7
  AST_LIMIT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (lim >= CNT_W'(MIN_TO)) && (lim <= CNT_W'(MAX_TO))); // R8
  AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1) |=> $stable(lim)); // R9
endmodule

bind seqstep_top seqstep_chk #(.MIN_TO(MIN_TO), .MAX_TO(MAX_TO)) u_chk (
  .clk(clk), .rst(rst), .restart(restart), .rail_good(rail_good),
  .state_o(state_o), .supply_en(supply_en), .next_en(next_en),
  .fault_o(fault_o), .cnt(tmr_cnt), .lim(lim)
);

// File: tb/sim_seqstep_top.sv
module sim_seqstep_top;
  localparam int TO_W   = 8;
  localparam int MIN_TO = 4;
  localparam int MAX_TO = 40;
  localparam int NEVER  = 100000;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, restart = 1'b0;
  logic tick = 1'b0, rail_good = 1'b0;
  logic [TO_W-1:0] timeout_us = '0;
  logic supply_en, next_en, fault_o;
  logic [1:0] state_o;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  seqstep_top #(.TO_W(TO_W), .MIN_TO(MIN_TO), .MAX_TO(MAX_TO)) u0 (
    .clk(clk), .rst(rst), .start(start), .restart(restart), .tick(tick),
    .rail_good(rail_good), .timeout_us(timeout_us), .supply_en(supply_en),
    .next_en(next_en), .fault_o(fault_o), .state_o(state_o)
  );

  task automatic chk_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected outputs follow the state: 0 idle, 1 wait, 2 done, 3 fault.
  task automatic check_outs(string req, int st);
    chk_eq(req, "state", int'(state_o), st);
    chk_eq(req, "supply_en", int'(supply_en), (st == 1 || st == 2) ? 1 : 0);
    chk_eq(req, "next_en", int'(next_en), (st == 2) ? 1 : 0);
    chk_eq(req, "fault_o", int'(fault_o), (st == 3) ? 1 : 0);
  endtask

  function automatic int clampf(int s);
    if (s < MIN_TO) return MIN_TO;
    if (s > MAX_TO) return MAX_TO;
    return s;
  endfunction

  // One full step: start, wait against a per-cycle model, then hold and restart.
  task automatic run_case(int setting, int arrival, int per, bit disturb);
    int lim = clampf(setting);
    int cnt = 0;
    int exp_st = 1;
    int c = 0;
    string req;
    timeout_us = TO_W'(setting);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_outs("R2", 1);
    if (disturb) timeout_us = TO_W'((lim == MIN_TO) ? MAX_TO : MIN_TO);
    while (exp_st == 1) begin
      tick = ((c % per) == 0);
      rail_good = (cnt >= arrival);
      req = "R3";
      if (rail_good) begin
        exp_st = 2;
        req = (cnt >= lim) ? "R6" : "R4";
      end else if (cnt >= lim) begin
        exp_st = 3;
        req = disturb ? "R9" : (setting != lim ? "R8" : "R5");
      end else if (tick) begin
        cnt++;
      end
      @(negedge clk);
      c++;
      check_outs(req, exp_st);
    end
    tick = 1'b0;
    rail_good = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_outs("R2", exp_st);
    @(negedge clk);
    check_outs("R7", exp_st);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    check_outs("R7", 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int sets[6] = '{4, 5, 9, 40, 2, 200};
    repeat (3) @(negedge clk);
    check_outs("R1", 0);
    rst = 1'b0;
    @(negedge clk);
    check_outs("R1", 0);

    // Idle ignores restart and rail_good
    restart = 1'b1;
    rail_good = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    rail_good = 1'b0;
    check_outs("R7", 0);

    // Restart ignored while waiting, then a good rail finishes the step
    timeout_us = TO_W'(10);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    check_outs("R7", 1);
    rail_good = 1'b1;
    @(negedge clk);
    rail_good = 1'b0;
    check_outs("R4", 2);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    check_outs("R7", 0);

    // Reset in the middle of a wait
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_outs("R2", 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_outs("R1", 0);

    // Sweep the arrival of rail_good across each limit, two tick rates
    foreach (sets[i]) begin
      for (int per = 1; per <= 3; per += 2) begin
        for (int a = 0; a <= clampf(sets[i]) + 2; a++)
          run_case(sets[i], a, per, bit'(a % 2));
        run_case(sets[i], NEVER, per, 1'b0);
      end
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule